// File: doc/BRIEF.md
# Victim and Probe Buffer Tracker

This block keeps the bookkeeping for the eight write-back staging buffers of a cache controller, plus the four buffers used for outbound I/O writes. Each staging buffer holds a line address and two flags that are set and cleared independently. One flag says the buffer holds an evicted line, which is a victim. The other says a coherence probe still owns the buffer. A buffer can be reused only when both flags are clear. Evictions of dirty lines, and optional clean evictions, claim a buffer. So does a probe that must move data out of a dirty line.

Release commands from the system side carry a 4-bit identifier. Identifiers below eight address the staging buffers, and identifiers eight to eleven address the I/O write buffers. A victim release clears the victim flag. A probe release clears the probe flag, but only when it arrives with a write-data or release-buffer command.

Probes enter a small in-order queue, and only the head probe is considered in each cycle. The head probe waits in four cases: its address matches a buffer that a probe still owns; it needs a buffer and none is free; it needs a buffer and an eviction takes one in the same cycle; or it misses everywhere while duplicate-tag mode is on. In every other case it is answered one cycle later with a response code and a buffer identifier.

Top module: `evict_probe_tracker`

## Requirements
- R1: After reset every victim flag, probe flag and I/O buffer busy bit is clear, the probe queue is empty, `full`, `probe_stall` and `resp_valid` are low, and `pq_ready` is high.
- R2: A dirty eviction request (`alloc_req` with `alloc_clean`=0) is granted in the same cycle to the lowest-numbered buffer whose two flags are both clear, and that buffer's victim flag is set from the next cycle. When no buffer is free, `full` is high and no grant is given.
- R3: A clean eviction request (`alloc_clean`=1) is granted only while `clean_vic_en` is 1. Otherwise it gets no grant and changes no state.
- R4: `rel_valid` with `rel_victim` and `rel_id` in 0..7 clears the victim flag of that buffer from the next cycle. A release aimed at a flag that is already clear has no effect. A buffer counts as free only when both of its flags are clear.
- R5: `rel_valid` with `rel_probe` and `rel_id` in 0..7 clears that buffer's probe flag only when `rel_cmd` is 1 (write data) or 2 (release buffer). Codes 0 and 3 leave the flag unchanged, and so does an identifier of 8 or more.
- R6: An `io_req` is granted to the lowest idle I/O write buffer and sets its busy bit. A victim release with `rel_id` bit 3 set (8..11) clears busy bit `rel_id`-8.
- R7: While the head probe's address equals the address of a buffer whose probe flag is set, `probe_stall` is high, the probe stays at the head, and no response is produced.
- R8: A head probe that matches a buffer whose victim flag is set and whose probe flag is clear sets that buffer's probe flag. In the next cycle it gives `resp_code`=2 and `resp_id` equal to that buffer.
- R9: A head probe with no buffer match that hits a dirty line claims the lowest free buffer, setting only its probe flag, and answers with `resp_code`=3 and that buffer's id. If no buffer is free, or an eviction is granted in the same cycle, it stalls instead. A hit on a clean line answers with `resp_code`=1 and id 0.
- R10: A head probe that misses both the cache and every buffer answers with `resp_code`=0 when `dup_tag_en`=0, and stalls when `dup_tag_en`=1.
- R11: Probes leave the queue in arrival order. `pq_ready` is high while fewer than `PQ_DEPTH` probes are queued, and a push while it is low is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dup_tag_en | input | 1 | Duplicate-tag mode: stall total misses instead of answering |
| clean_vic_en | input | 1 | Permit clean evictions to claim a buffer |
| alloc_req | input | 1 | Eviction wants a staging buffer |
| alloc_clean | input | 1 | 1 = clean eviction, 0 = dirty eviction |
| alloc_addr | input | ADDR_W | Line address of the eviction |
| alloc_gnt | output | 1 | Eviction granted this cycle |
| alloc_id | output | VDB_W | Buffer granted (valid with grant) |
| full | output | 1 | No staging buffer is free |
| io_req | input | 1 | I/O write wants a buffer |
| io_gnt | output | 1 | I/O write granted |
| io_id | output | IO_W | I/O buffer granted |
| io_busy | output | N_IOWB | Busy bit per I/O write buffer |
| rel_valid | input | 1 | System release command present |
| rel_victim | input | 1 | Release the victim flag or I/O buffer |
| rel_probe | input | 1 | Release the probe flag |
| rel_cmd | input | 2 | 0 other, 1 write data, 2 release buffer, 3 read data |
| rel_id | input | ID_W | Target identifier |
| pq_push | input | 1 | Enqueue a probe |
| pq_addr | input | ADDR_W | Probe line address |
| pq_ready | output | 1 | Probe queue has room |
| lk_addr | output | ADDR_W | Head probe address sent to the cache lookup |
| lk_hit | input | 1 | Cache lookup hit for `lk_addr` |
| lk_dirty | input | 1 | Hit line is dirty |
| probe_stall | output | 1 | Head probe present and held this cycle |
| resp_valid | output | 1 | Probe response valid |
| resp_code | output | 2 | 0 miss, 1 clean hit, 2 buffer hit, 3 data moved |
| resp_id | output | ID_W | Buffer tied to the response |
| vic_valid | output | N_VDB | Victim flag per buffer |
| prb_valid | output | N_VDB | Probe flag per buffer |

## Verification
The bench builds the block with eight staging buffers, four I/O buffers, a four-entry probe queue and 8-bit addresses. All addresses come from a pool of twelve lines, so probes collide with buffer addresses all the time. That pool, together with eight buffers, makes running out of buffers, stalls on probe-owned buffers, and a dirty-hit probe competing with an eviction for the last free buffer common events, not rare ones. Release identifiers span 0..12, so victim, I/O and out-of-range targets all appear. Duplicate-tag mode and clean-eviction enable are toggled in phases, so both miss policies are exercised.

// File: rtl/evict_probe_tracker.sv
module evict_probe_tracker #(
  parameter int N_VDB    = 8,
  parameter int N_IOWB   = 4,
  parameter int ADDR_W   = 16,
  parameter int PQ_DEPTH = 4,
  localparam int VDB_W = $clog2(N_VDB),
  localparam int IO_W  = (N_IOWB > 1) ? $clog2(N_IOWB) : 1,
  localparam int ID_W  = $clog2(N_VDB + N_IOWB),
  localparam int PQ_W  = $clog2(PQ_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dup_tag_en,
  input  logic              clean_vic_en,
  input  logic              alloc_req,
  input  logic              alloc_clean,
  input  logic [ADDR_W-1:0] alloc_addr,
  output logic              alloc_gnt,
  output logic [VDB_W-1:0]  alloc_id,
  output logic              full,
  input  logic              io_req,
  output logic              io_gnt,
  output logic [IO_W-1:0]   io_id,
  output logic [N_IOWB-1:0] io_busy,
  input  logic              rel_valid,
  input  logic              rel_victim,
  input  logic              rel_probe,
  input  logic [1:0]        rel_cmd,
  input  logic [ID_W-1:0]   rel_id,
  input  logic              pq_push,
  input  logic [ADDR_W-1:0] pq_addr,
  output logic              pq_ready,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_hit,
  input  logic              lk_dirty,
  output logic              probe_stall,
  output logic              resp_valid,
  output logic [1:0]        resp_code,
  output logic [ID_W-1:0]   resp_id,
  output logic [N_VDB-1:0]  vic_valid,
  output logic [N_VDB-1:0]  prb_valid
);

  localparam logic [1:0] C_MISS = 2'd0, C_CLEAN = 2'd1, C_BUF = 2'd2, C_DATA = 2'd3;

  logic [N_VDB-1:0]  vv, pv;
  logic [ADDR_W-1:0] ea [N_VDB];
  logic [N_IOWB-1:0] iob;

  logic [ADDR_W-1:0] pq [PQ_DEPTH];
  logic [PQ_W-1:0]   rp, wp;
  logic [PQ_W:0]     cnt;
  logic              head_v;

  assign vic_valid = vv;
  assign prb_valid = pv;
  assign io_busy   = iob;
  assign head_v    = (cnt != '0);
  assign lk_addr   = pq[rp];
  assign pq_ready  = (cnt < (PQ_W+1)'(PQ_DEPTH));

  logic [N_VDB-1:0] free;
  logic [VDB_W-1:0] fidx;
  logic             fany;
  assign free = ~(vv | pv);

  always_comb begin
    fidx = '0;
    fany = 1'b0;
    for (int i = N_VDB-1; i >= 0; i--)
      if (free[i]) begin
        fidx = VDB_W'(i);
        fany = 1'b1;
      end
  end

  assign full      = ~fany;
  assign alloc_gnt = alloc_req & (~alloc_clean | clean_vic_en) & fany;
  assign alloc_id  = fidx;

  logic io_any;
  always_comb begin
    io_id  = '0;
    io_any = 1'b0;
    for (int j = N_IOWB-1; j >= 0; j--)
      if (!iob[j]) begin
        io_id  = IO_W'(j);
        io_any = 1'b1;
      end
  end
  assign io_gnt = io_req & io_any;

  logic [N_VDB-1:0] pmatch, vmatch;
  logic [VDB_W-1:0] vidx;
  always_comb begin
    vidx = '0;
    for (int i = N_VDB-1; i >= 0; i--) begin
      pmatch[i] = pv[i] & (ea[i] == lk_addr);
      vmatch[i] = vv[i] & ~pv[i] & (ea[i] == lk_addr);
      if (vmatch[i]) vidx = VDB_W'(i);
    end
  end

  logic            acc, take_new;
  logic [1:0]      code;
  logic [ID_W-1:0] id;
  always_comb begin
    acc      = 1'b0;
    take_new = 1'b0;
    code     = C_MISS;
    id       = '0;
    if (head_v && !(|pmatch)) begin
      if (|vmatch) begin
        acc  = 1'b1;
        code = C_BUF;
        id   = ID_W'(vidx);
      end else if (lk_hit && lk_dirty) begin
        if (fany && !alloc_gnt) begin
          acc      = 1'b1;
          take_new = 1'b1;
          code     = C_DATA;
          id       = ID_W'(fidx);
        end
      end else if (lk_hit) begin
        acc  = 1'b1;
        code = C_CLEAN;
      end else if (!dup_tag_en) begin
        acc = 1'b1;
      end
    end
  end
  assign probe_stall = head_v & ~acc;

  logic rel_pv_ok;
  assign rel_pv_ok = rel_valid & rel_probe & (rel_cmd == 2'd1 || rel_cmd == 2'd2);

  for (genvar i = 0; i < N_VDB; i++) begin : g_ent
    logic set_v, clr_v, set_p, clr_p;
    assign set_v = alloc_gnt & (fidx == VDB_W'(i));
    assign clr_v = rel_valid & rel_victim & (rel_id == ID_W'(i));
    assign set_p = (acc & (code == C_BUF) & (vidx == VDB_W'(i))) |
                   (take_new & (fidx == VDB_W'(i)));
    assign clr_p = rel_pv_ok & (rel_id == ID_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vv[i] <= 1'b0;
        pv[i] <= 1'b0;
        ea[i] <= '0;
      end else begin
        if (set_v)      vv[i] <= 1'b1;
        else if (clr_v) vv[i] <= 1'b0;
        if (set_p)      pv[i] <= 1'b1;
        else if (clr_p) pv[i] <= 1'b0;
        if (set_v)      ea[i] <= alloc_addr;
        else if (take_new && fidx == VDB_W'(i)) ea[i] <= lk_addr;
      end
    end
  end

  for (genvar j = 0; j < N_IOWB; j++) begin : g_io
    always_ff @(posedge clk) begin
      if (!rst_n) iob[j] <= 1'b0;
      else if (io_gnt && io_id == IO_W'(j)) iob[j] <= 1'b1;
      else if (rel_valid && rel_victim && rel_id == ID_W'(N_VDB + j)) iob[j] <= 1'b0;
    end
  end

  logic push;
  assign push = pq_push & pq_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
      for (int k = 0; k < PQ_DEPTH; k++) pq[k] <= '0;
    end else begin
      if (push) begin
        pq[wp] <= pq_addr;
        wp     <= wp + 1'b1;
      end
      if (acc) rp <= rp + 1'b1;
      cnt <= cnt + (PQ_W+1)'(push) - (PQ_W+1)'(acc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_code  <= C_MISS;
      resp_id    <= '0;
    end else begin
      resp_valid <= acc;
      resp_code  <= code;
      resp_id    <= id;
    end
  end

endmodule

module evict_probe_tracker_chk #(
  parameter int N_VDB = 8,
  parameter int ID_W  = 4,
  localparam int VW   = $clog2(N_VDB)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dup_tag_en,
  input logic             alloc_gnt,
  input logic [VW-1:0]    alloc_id,
  input logic             full,
  input logic             rel_valid,
  input logic             rel_victim,
  input logic [ID_W-1:0]  rel_id,
  input logic             probe_stall,
  input logic             resp_valid,
  input logic [1:0]       resp_code,
  input logic [ID_W-1:0]  resp_id,
  input logic [N_VDB-1:0] vic_valid,
  input logic [N_VDB-1:0] prb_valid
);

  // R2
  grant_sets_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |=> vic_valid[$past(alloc_id)]);

  // R2
  full_means_all_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (&(vic_valid | prb_valid) && !alloc_gnt));

  // R4
  victim_release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && rel_victim && rel_id < ID_W'(N_VDB) && vic_valid[rel_id[VW-1:0]])
      |=> !vic_valid[$past(rel_id[VW-1:0])]);

  // R7
  stall_no_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_stall |=> !resp_valid);

  // R8
  buffer_resp_owns_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code[1]) |-> prb_valid[resp_id[VW-1:0]]);

  // R10
  miss_only_without_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code == 2'd0) |-> !$past(dup_tag_en));

endmodule

bind evict_probe_tracker evict_probe_tracker_chk #(.N_VDB(N_VDB), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dup_tag_en(dup_tag_en), .alloc_gnt(alloc_gnt),
  .alloc_id(alloc_id), .full(full), .rel_valid(rel_valid), .rel_victim(rel_victim),
  .rel_id(rel_id), .probe_stall(probe_stall), .resp_valid(resp_valid),
  .resp_code(resp_code), .resp_id(resp_id), .vic_valid(vic_valid), .prb_valid(prb_valid)
);

// File: tb/evict_probe_tracker_test.sv
`timescale 1ns/1ps
module evict_probe_tracker_test;
  localparam int NV = 8, NI = 4, AW = 8, QD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic dup_tag_en, clean_vic_en, alloc_req, alloc_clean, io_req;
  logic rel_valid, rel_victim, rel_probe, pq_push;
  logic [1:0] rel_cmd;
  logic [3:0] rel_id;
  logic [AW-1:0] alloc_addr, pq_addr, lk_addr;
  logic alloc_gnt, full, io_gnt, pq_ready, probe_stall, resp_valid, lk_hit, lk_dirty;
  logic [2:0] alloc_id;
  logic [1:0] io_id, resp_code;
  logic [3:0] io_busy, resp_id;
  logic [NV-1:0] vic_valid, prb_valid;

  function automatic logic c_hit(input logic [AW-1:0] a); return (a % 4) != 0; endfunction
  function automatic logic c_dirty(input logic [AW-1:0] a); return (a % 4) == 3; endfunction
  assign lk_hit   = c_hit(lk_addr);
  assign lk_dirty = c_dirty(lk_addr);

  evict_probe_tracker #(.N_VDB(NV), .N_IOWB(NI), .ADDR_W(AW), .PQ_DEPTH(QD)) uut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  logic [NV-1:0] m_vv, m_pv;
  int m_ea [NV];
  logic [NI-1:0] m_io;
  int mq [$];
  logic er_v;
  int er_code, er_id;

  task automatic idle();
    alloc_req = 0; alloc_clean = 0; alloc_addr = '0; io_req = 0;
    rel_valid = 0; rel_victim = 0; rel_probe = 0; rel_cmd = 0; rel_id = 0;
    pq_push = 0; pq_addr = '0;
  endtask

  task automatic tick();
    logic [NV-1:0] fr;
    int fidx, vidx, iidx, hd, code, id;
    bit fany, ok, gnt, ioany, iog, hv, pm, vm, acc, tnew;
    #1;
    fr = ~(m_vv | m_pv); fany = 0; fidx = 0;
    for (int i = NV-1; i >= 0; i--) if (fr[i]) begin fidx = i; fany = 1; end
    ok  = alloc_req && (!alloc_clean || clean_vic_en);
    gnt = ok && fany;
    ioany = 0; iidx = 0;
    for (int j = NI-1; j >= 0; j--) if (!m_io[j]) begin iidx = j; ioany = 1; end
    iog = io_req && ioany;
    hv = mq.size() > 0; hd = hv ? mq[0] : 0;
    pm = 0; vm = 0; vidx = 0;
    for (int i = NV-1; i >= 0; i--) begin
      if (m_pv[i] && m_ea[i] == hd) pm = 1;
      if (m_vv[i] && !m_pv[i] && m_ea[i] == hd) begin vm = 1; vidx = i; end
    end
    acc = 0; tnew = 0; code = 0; id = 0;
    if (hv && !pm) begin
      if (vm) begin acc = 1; code = 2; id = vidx; end
      else if (c_hit(hd[AW-1:0]) && c_dirty(hd[AW-1:0])) begin
        if (fany && !gnt) begin acc = 1; tnew = 1; code = 3; id = fidx; end
      end else if (c_hit(hd[AW-1:0])) begin acc = 1; code = 1; end
      else if (!dup_tag_en) acc = 1;
    end

    chk("R2", "full", int'(full), int'(!fany));
    chk(alloc_clean ? "R3" : "R2", "alloc_gnt", int'(alloc_gnt), int'(gnt));
    if (gnt) chk("R2", "alloc_id", int'(alloc_id), fidx);
    chk("R6", "io_gnt", int'(io_gnt), int'(iog));
    if (iog) chk("R6", "io_id", int'(io_id), iidx);
    chk("R6", "io_busy", int'(io_busy), int'(m_io));
    chk("R4", "vic_valid", int'(vic_valid), int'(m_vv));
    chk("R5", "prb_valid", int'(prb_valid), int'(m_pv));
    chk(pm ? "R7" : (hv && !acc && !pm && !c_hit(hd[AW-1:0])) ? "R10" : "R9",
        "probe_stall", int'(probe_stall), int'(hv && !acc));
    chk("R11", "pq_ready", int'(pq_ready), int'(mq.size() < QD));
    chk("R7", "resp_valid", int'(resp_valid), int'(er_v));
    if (er_v) begin
      chk(er_code == 2 ? "R8" : er_code == 0 ? "R10" : "R9", "resp_code", int'(resp_code), er_code);
      chk(er_code == 2 ? "R8" : "R9", "resp_id", int'(resp_id), er_id);
    end

    if (gnt) begin m_vv[fidx] = 1; m_ea[fidx] = int'(alloc_addr); end
    if (acc && code == 2) m_pv[vidx] = 1;
    if (tnew) begin m_pv[fidx] = 1; m_ea[fidx] = hd; end
    if (rel_valid && rel_victim && rel_id < NV && !(gnt && fidx == rel_id)) m_vv[rel_id] = 0;
    if (rel_valid && rel_probe && (rel_cmd == 1 || rel_cmd == 2) && rel_id < NV &&
        !(acc && code == 2 && vidx == rel_id) && !(tnew && fidx == rel_id)) m_pv[rel_id] = 0;
    if (iog) m_io[iidx] = 1;
    else if (rel_valid && rel_victim && rel_id >= NV && rel_id < NV + NI) m_io[rel_id - NV] = 0;
    if (rel_valid && rel_victim && rel_id >= NV && rel_id < NV + NI && iog && iidx != rel_id - NV)
      m_io[rel_id - NV] = 0;
    if (acc) void'(mq.pop_front());
    if (pq_push && (mq.size() + (acc ? 1 : 0)) < QD + (acc ? 1 : 0) && (mq.size() + (acc ? 1 : 0)) < QD)
      mq.push_back(int'(pq_addr));
    er_v = acc; er_code = code; er_id = id;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int s;
    s = $urandom(32'h1F2E);
    idle(); dup_tag_en = 0; clean_vic_en = 0;
    m_vv = '0; m_pv = '0; m_io = '0; er_v = 0;
    for (int i = 0; i < NV; i++) m_ea[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", "flags", int'({vic_valid, prb_valid, io_busy}), 0);
    chk("R1", "outs", int'({full, probe_stall, resp_valid, pq_ready}), 1);
    @(negedge clk);

    // R3 clean eviction while disabled, then enabled
    alloc_req = 1; alloc_clean = 1; alloc_addr = 8'd4; tick();
    clean_vic_en = 1; tick();
    // R2 fill every buffer, then one more request while full
    alloc_clean = 0;
    for (int k = 0; k < NV; k++) begin alloc_addr = AW'(k + 5); tick(); end
    idle(); tick();
    // R4 release victim 3 twice; second aims at a clear flag
    rel_valid = 1; rel_victim = 1; rel_id = 3; tick(); tick();
    idle(); alloc_req = 1; alloc_addr = 8'd2; tick();
    // R8 probe hits buffer 0 (addr 4), then R7 same address stalls
    idle(); pq_push = 1; pq_addr = 8'd4; tick(); tick();
    idle(); tick(); tick(); tick();
    // R5 probe release with read-data code ignored, then write-data clears
    rel_valid = 1; rel_probe = 1; rel_cmd = 2'd3; rel_id = 0; tick();
    rel_cmd = 2'd1; tick();
    idle(); tick(); tick();
    rel_valid = 1; rel_probe = 1; rel_cmd = 2'd2; rel_id = 0; tick();
    // R6 four I/O buffers, then release id 9 (bit 3 set)
    idle(); io_req = 1; repeat (5) tick();
    idle(); rel_valid = 1; rel_victim = 1; rel_id = 4'd9; tick();
    idle(); io_req = 1; tick();
    // R10 total miss with duplicate-tag on, then off
    idle(); for (int k = 0; k < NV; k++) begin rel_valid = 1; rel_victim = 1; rel_probe = 1; rel_cmd = 1; rel_id = 4'(k); tick(); end
    idle(); dup_tag_en = 1; pq_push = 1; pq_addr = 8'd8; tick();
    idle(); tick(); tick();
    dup_tag_en = 0; tick(); tick();
    // R9 dirty hit claims a buffer; clean hit answers code 1
    pq_push = 1; pq_addr = 8'd3; tick(); pq_addr = 8'd1; tick();
    idle(); repeat (3) tick();
    // R11 overflow the queue while head is blocked
    dup_tag_en = 1; pq_push = 1; pq_addr = 8'd0; repeat (6) tick();
    idle(); dup_tag_en = 0; repeat (6) tick();

    // constrained random phase
    for (int c = 0; c < 6000; c++) begin
      if (c % 300 == 0) dup_tag_en = ($urandom % 3) == 0;
      if (c % 500 == 0) clean_vic_en = $urandom % 2;
      alloc_req   = ($urandom % 10) < 3;
      alloc_clean = $urandom % 2;
      alloc_addr  = AW'($urandom % 12);
      io_req      = ($urandom % 7) == 0;
      rel_valid   = ($urandom % 10) < 4;
      rel_victim  = $urandom % 2;
      rel_probe   = $urandom % 2;
      rel_cmd     = 2'($urandom % 4);
      rel_id      = 4'($urandom % 13);
      pq_push     = ($urandom % 10) < 4;
      pq_addr     = AW'($urandom % 12);
      tick();
    end
    idle(); dup_tag_en = 0; repeat (20) tick();

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule